// File: doc/BRIEF.md
# Receiver Error Mask and Concealment Controller

This block sits behind the line decoder of a digital audio receiver. On every sample strobe it takes the seven per-frame error flags together with the 24-bit sample. A host mask register selects which error classes count. Each counted error is recorded in a sticky register that the host reads and clears. It also produces a one-clock error pulse and keeps an interrupt request high.

A counted error that can damage audio also conceals the sample. A two-bit hold mode picks the concealment: repeat the last good sample, output zero, or pass the sample through. The two CRC-class errors, for the Q-subcode and the channel-status block, are reported but never alter audio. The host samples `err_reg` and asserts `rd_stb` for one clock to clear it.

Top module: `rx_err_ctrl`

## Requirements
- R1: On a clock where `smp_valid` is 1, each flag bit with its mask bit at 1 sets the matching `err_reg` bit one clock later. The bit positions are 0 parity, 1 bi-phase, 2 confidence, 3 lock, 4 validity, 5 Q-subcode CRC and 6 channel-status CRC.
- R2: A flag whose mask bit is 0 has no effect. It sets no register bit, gives no pulse and no interrupt, and does not change the output sample. Flags on clocks without `smp_valid` are also ignored.
- R3: `err_pulse` is 1 for exactly the one clock after a strobe that carries at least one unmasked error. It is 0 at all other times.
- R4: `irq` is 1 whenever any `err_reg` bit is set, and 0 otherwise.
- R5: `err_reg` bits are sticky. A clock with `rd_stb` at 1 clears them. An unmasked error on that same clock stays set.
- R6: Hold mode 2'b00, and likewise 2'b11, outputs the last good sample when a concealing error is present.
- R7: Hold mode 2'b01 outputs zero when a concealing error is present.
- R8: Hold mode 2'b10 outputs the incoming sample unchanged even when a concealing error is present.
- R9: Unmasked errors on bits 5 and 6 never conceal. The sample passes through, but the errors are still recorded and still raise `irq`.
- R10: A strobe with no concealing error outputs `smp_in` unchanged one clock later. `smp_out_valid` is 1 for that one clock.
- R11: The last good sample is taken only from strobes that carry no concealing error. Pass-through of an errored sample in mode 2'b10 does not update it.
- R12: After reset, `err_reg`, `err_pulse`, `irq`, `smp_out`, `smp_out_valid` and the last good sample are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_flags | input | 7 | Per-frame error flags, qualified by `smp_valid` |
| err_mask | input | 7 | 1 enables the matching error class |
| hold_mode | input | 2 | Concealment selection |
| smp_in | input | 24 | Incoming audio sample |
| smp_valid | input | 1 | Sample strobe |
| rd_stb | input | 1 | Host read strobe; clears `err_reg` |
| err_reg | output | 7 | Sticky error register |
| err_pulse | output | 1 | One-clock error pulse |
| irq | output | 1 | Interrupt request, level |
| smp_out | output | 24 | Corrected sample |
| smp_out_valid | output | 1 | Output sample strobe |

## Verification
Every result of a strobe is registered once, so it is due exactly one clock after the edge that sees `smp_valid`. This covers the register bits, the pulse, the interrupt and the output sample. A read clears on the edge where `rd_stb` is high. The bench changes inputs on falling edges and compares every output at the next falling edge against a model that is stepped once per edge. Idle clocks between strobes confirm that the pulse and the output strobe stay low and the sample holds.

// File: rtl/rxerr_pkg.sv
// Shared types for the receiver error controller.
// Assumes: a two-bit hold-mode field where 2'b11 aliases repeat.
package rxerr_pkg;
    localparam int ERR_CLASSES = 7;

    typedef enum logic [1:0] {
        HOLD_REPEAT     = 2'b00,
        HOLD_ZERO       = 2'b01,
        HOLD_PASS       = 2'b10,
        HOLD_REPEAT_ALT = 2'b11
    } hold_e;
endpackage

// File: rtl/rxerr_qualify.sv
// Gates the raw error flags with the mask and the sample strobe.
// Produces the active vector, an any-error flag and a concealment request.
// Assumes: the flags are only meaningful on strobe clocks.
module rxerr_qualify #(
    parameter int               ERR_W       = 7,
    parameter logic [ERR_W-1:0] NOCONCEAL   = 7'b110_0000
) (
    input  logic [ERR_W-1:0] flags,
    input  logic [ERR_W-1:0] mask,
    input  logic             strobe,
    output logic [ERR_W-1:0] active,
    output logic             any_active,
    output logic             conceal
);
    logic [ERR_W-1:0] harm;

    // Per-class gating; the CRC-class positions never request concealment.
    for (genvar i = 0; i < ERR_W; i++) begin : g_bit
        assign active[i] = flags[i] & mask[i] & strobe;
        if (NOCONCEAL[i]) begin : g_crc
            assign harm[i] = 1'b0;
        end else begin : g_audio
            assign harm[i] = active[i];
        end
    end

    // Reduce the per-bit results.
    always_comb begin
        any_active = |active;
        conceal    = |harm;
    end
endmodule

// File: rtl/rxerr_sticky.sv
// Sticky error register with read-to-clear, error pulse and interrupt.
// Assumes: a set on the read clock takes priority over the clear.
module rxerr_sticky #(
    parameter int ERR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] active,
    input  logic             any_active,
    input  logic             rd_stb,
    output logic [ERR_W-1:0] status,
    output logic             pulse,
    output logic             irq
);
    // One sticky bit per error class.
    for (genvar i = 0; i < ERR_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         status[i] <= 1'b0;
            else if (active[i]) status[i] <= 1'b1;
            else if (rd_stb)    status[i] <= 1'b0;
        end
    end

    // One-clock pulse per strobe that carried an unmasked error.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= any_active;
    end

    // Level interrupt while anything is recorded.
    always_comb irq = |status;
endmodule

// File: rtl/rxerr_conceal.sv
// Sample concealment: repeat, zero or pass on a concealing error.
// Assumes: the last good sample is updated only on clean strobes.
module rxerr_conceal #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             strobe,
    input  logic             conceal,
    input  logic [1:0]       hold_mode,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_out_valid
);
    import rxerr_pkg::*;

    hold_e            mode;
    logic [SMP_W-1:0] last_good;
    logic [SMP_W-1:0] chosen;

    // Select the sample to emit on this strobe.
    always_comb begin
        mode   = hold_e'(hold_mode);
        chosen = smp_in;
        if (conceal) begin
            unique case (mode)
                HOLD_ZERO:       chosen = '0;
                HOLD_PASS:       chosen = smp_in;
                HOLD_REPEAT,
                HOLD_REPEAT_ALT: chosen = last_good;
                default:         chosen = last_good;
            endcase
        end
    end

    // Track the most recent clean sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_good <= '0;
        else if (strobe && !conceal) last_good <= smp_in;
    end

    // Register the output sample and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out       <= '0;
            smp_out_valid <= 1'b0;
        end else begin
            smp_out_valid <= strobe;
            if (strobe) smp_out <= chosen;
        end
    end
endmodule

// File: rtl/rx_err_ctrl.sv
// Top of the receiver error controller: mask gating, sticky reporting
// with read-to-clear, error pulse, interrupt and sample concealment.
// Assumes: all outputs are registered one clock after the strobe.
module rx_err_ctrl #(
    parameter int               SMP_W     = 24,
    parameter int               ERR_W     = rxerr_pkg::ERR_CLASSES,
    parameter logic [ERR_W-1:0] NOCONCEAL = 7'b110_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_flags,
    input  logic [ERR_W-1:0] err_mask,
    input  logic [1:0]       hold_mode,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             smp_valid,
    input  logic             rd_stb,
    output logic [ERR_W-1:0] err_reg,
    output logic             err_pulse,
    output logic             irq,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_out_valid
);
    logic [ERR_W-1:0] active;
    logic             any_active;
    logic             conceal;

    rxerr_qualify #(.ERR_W(ERR_W), .NOCONCEAL(NOCONCEAL)) u_qual (
        .flags(err_flags), .mask(err_mask), .strobe(smp_valid),
        .active(active), .any_active(any_active), .conceal(conceal)
    );

    rxerr_sticky #(.ERR_W(ERR_W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .active(active), .any_active(any_active),
        .rd_stb(rd_stb), .status(err_reg), .pulse(err_pulse), .irq(irq)
    );

    rxerr_conceal #(.SMP_W(SMP_W)) u_conc (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .strobe(smp_valid),
        .conceal(conceal), .hold_mode(hold_mode),
        .smp_out(smp_out), .smp_out_valid(smp_out_valid)
    );
endmodule

// File: rtl/rx_err_ctrl_chk.sv
// Property checker for rx_err_ctrl, attached by bind.
module rx_err_ctrl_chk #(
    parameter int               SMP_W     = 24,
    parameter int               ERR_W     = 7,
    parameter logic [ERR_W-1:0] NOCONCEAL = 7'b110_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ERR_W-1:0] err_flags,
    input logic [ERR_W-1:0] err_mask,
    input logic [1:0]       hold_mode,
    input logic [SMP_W-1:0] smp_in,
    input logic             smp_valid,
    input logic             rd_stb,
    input logic [ERR_W-1:0] err_reg,
    input logic             err_pulse,
    input logic             irq,
    input logic [SMP_W-1:0] smp_out,
    input logic             smp_out_valid
);
    // A strobe with an unmasked error sets the flagged bits.
    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ((err_reg & $past(err_flags & err_mask)) == $past(err_flags & err_mask)));

    // A strobe whose flags are all masked gives no pulse.
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ((err_flags & err_mask) == '0)) |=> !err_pulse);

    // A pulse follows every strobe with an unmasked error.
    p_pulse_after_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ((err_flags & err_mask) != '0)) |=> err_pulse);

    // No pulse without a strobe.
    p_pulse_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !err_pulse);

    // A read with no new error leaves the interrupt low.
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !smp_valid) |=> (!irq && err_reg == '0));

    // Without a read, set bits stay set.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((err_reg & $past(err_reg)) == $past(err_reg)));

    // Zero mode with a concealing error outputs zero.
    p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && hold_mode == 2'b01 && ((err_flags & err_mask & ~NOCONCEAL) != '0))
        |=> smp_out == '0);

    // Pass mode always forwards the sample.
    p_pass_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && hold_mode == 2'b10) |=> smp_out == $past(smp_in));

    // Without a concealing error, CRC-class or not, the sample passes.
    p_crc_no_conceal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ((err_flags & err_mask & ~NOCONCEAL) == '0))
        |=> (smp_out == $past(smp_in) && smp_out_valid));
endmodule

bind rx_err_ctrl rx_err_ctrl_chk #(
    .SMP_W(SMP_W), .ERR_W(ERR_W), .NOCONCEAL(NOCONCEAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .err_mask(err_mask),
    .hold_mode(hold_mode), .smp_in(smp_in), .smp_valid(smp_valid),
    .rd_stb(rd_stb), .err_reg(err_reg), .err_pulse(err_pulse), .irq(irq),
    .smp_out(smp_out), .smp_out_valid(smp_out_valid)
);

// File: tb/rx_err_ctrl_test.sv
// Sweep bench: all flag patterns x several masks x all hold modes.
module rx_err_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  err_flags = '0;
    logic [6:0]  err_mask = '0;
    logic [1:0]  hold_mode = '0;
    logic [23:0] smp_in = '0;
    logic        smp_valid = 1'b0;
    logic        rd_stb = 1'b0;
    logic [6:0]  err_reg;
    logic        err_pulse;
    logic        irq;
    logic [23:0] smp_out;
    logic        smp_out_valid;

    int n_run = 0;
    int n_fail = 0;

    logic [6:0]  m_reg = '0;
    logic [23:0] m_good = '0;
    logic [23:0] m_out = '0;

    rx_err_ctrl uut (
        .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .err_mask(err_mask),
        .hold_mode(hold_mode), .smp_in(smp_in), .smp_valid(smp_valid),
        .rd_stb(rd_stb), .err_reg(err_reg), .err_pulse(err_pulse), .irq(irq),
        .smp_out(smp_out), .smp_out_valid(smp_out_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one clock of stimulus at a falling edge, step the model, check at the next falling edge.
    task automatic step(input logic [6:0] f, input logic [6:0] m, input logic [1:0] md,
                        input logic [23:0] s, input logic v, input logic rd);
        logic [6:0] act;
        logic       conc;
        logic [23:0] prev_out;
        err_flags = f; err_mask = m; hold_mode = md; smp_in = s; smp_valid = v; rd_stb = rd;
        act  = v ? (f & m) : 7'd0;
        conc = (act & 7'b001_1111) != 0;
        prev_out = m_out;
        m_reg = (rd ? 7'd0 : m_reg) | act;
        if (v) begin
            if (!conc) begin m_out = s; m_good = s; end
            else if (md == 2'b01) m_out = '0;
            else if (md == 2'b10) m_out = s;
            else m_out = m_good;
        end
        @(negedge clk);
        check(rd ? "R5 err_reg" : "R1 err_reg", 32'(err_reg), 32'(m_reg));
        check(v ? "R3 err_pulse" : "R2 err_pulse idle", 32'(err_pulse), 32'(act != 0));
        check("R4 irq", 32'(irq), 32'(m_reg != 0));
        check("R10 smp_out_valid", 32'(smp_out_valid), 32'(v));
        if (!v)                   check("R2 smp_out held", 32'(smp_out), 32'(prev_out));
        else if (!conc)           check((act != 0) ? "R9 smp_out" : "R10 smp_out", 32'(smp_out), 32'(m_out));
        else if (md == 2'b01)     check("R7 smp_out", 32'(smp_out), 32'(m_out));
        else if (md == 2'b10)     check("R8 smp_out", 32'(smp_out), 32'(m_out));
        else                      check("R6 smp_out", 32'(smp_out), 32'(m_out));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [6:0] masks [4];
        masks[0] = 7'h7F; masks[1] = 7'h00; masks[2] = 7'h55; masks[3] = 7'h60;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        check("R12 err_reg", 32'(err_reg), 0);
        check("R12 err_pulse", 32'(err_pulse), 0);
        check("R12 irq", 32'(irq), 0);
        check("R12 smp_out", 32'(smp_out), 0);
        check("R12 smp_out_valid", 32'(smp_out_valid), 0);
        // R12: last good sample is zero -> repeat before any clean strobe gives 0
        step(7'h01, 7'h7F, 2'b00, 24'hABCDEF, 1'b1, 1'b0);
        check("R12 last good zero", 32'(smp_out), 0);
        step(7'h00, 7'h00, 2'b00, 24'h0, 1'b0, 1'b1);
        // R11: clean sample, then pass-through errored sample, then repeat
        step(7'h00, 7'h7F, 2'b00, 24'h111111, 1'b1, 1'b0);
        step(7'h02, 7'h7F, 2'b10, 24'h222222, 1'b1, 1'b0);
        step(7'h04, 7'h7F, 2'b11, 24'h333333, 1'b1, 1'b0);
        check("R11 last good kept", 32'(smp_out), 32'h111111);
        // R5: read and new error on the same clock
        step(7'h08, 7'h7F, 2'b00, 24'h444444, 1'b1, 1'b1);
        check("R5 new error wins", 32'(err_reg), 32'h08);
        // R2: flags without strobe ignored
        step(7'h7F, 7'h7F, 2'b01, 24'h555555, 1'b0, 1'b1);
        check("R2 unstrobed flags", 32'(err_reg), 0);
        // Sweep
        for (int mi = 0; mi < 4; mi++) begin
            for (int md = 0; md < 4; md++) begin
                for (int f = 0; f < 128; f++) begin
                    step(7'(f), masks[mi], 2'(md), 24'(32'h13579B + f * 7919 + md * 101 + mi),
                         1'b1, (f % 3) == 0);
                    if (f % 16 == 0) step(7'h7F, 7'h7F, 2'(md), 24'hFFFFFF, 1'b0, 1'b0);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule